// File: doc/BRIEF.md
# Fine-Tuned Video Timing Generator

This block produces horizontal sync, vertical sync and blanking for a raster display. Its pixel rate does not come from a fixed clock. A phase accumulator adds a tuning word on every system clock, and each carry out of the accumulator is one pixel tick. The tuning word sets the pixel rate in steps of one part in 2^ACC_W of the system clock. The line and frame rates can therefore be trimmed continuously until the generated raster locks to the timing of an unknown external display. Every sync edge falls on a system clock edge.

A horizontal counter steps on each pixel tick. A vertical counter steps each time the horizontal counter wraps. For each axis, four programmable values set the length, the visible width and the start and end of the sync pulse, and one polarity bit sets the active level of that sync output. Software-style writes load the tuning word, the timing values and the polarities. A preset select loads a complete mode, computed from its index, in one cycle. Two pulse inputs nudge the tuning word up or down by one step. The block has no data stream: every pin is a plain level or a plain pulse, so no back-pressure rules apply.

Top module: `nco_sync_gen`

## Requirements
- R1: While reset is low and on the first clock after it is released, both counters are 0, pix_tick is 0, and preset 0 is active (tuning word 1<<(ACC_W-3), both polarities 0, so hsync=1, vsync=1 and blank=0).
- R2: The accumulator is ACC_W bits wide and adds the tuning word on every clock. pix_tick is high for the one cycle after each carry out. Over any 2^ACC_W consecutive clocks with a constant tuning word T, pix_tick is high on exactly T cycles, and on none when T is 0.
- R3: h_pos steps by one on the clock edge that follows each pix_tick cycle. On that edge it returns to 0 instead when h_pos+1 >= h_total. Without a tick it holds.
- R4: v_pos steps only on an edge where h_pos returns to 0. It returns to 0 instead when v_pos+1 >= v_total.
- R5: hsync equals the horizontal polarity bit while h_sync_start <= h_pos < h_sync_end, and its inverse otherwise. vsync follows the same rule using v_pos and the vertical values. A polarity bit of 1 means active high.
- R6: blank is 1 when h_pos >= h_active or v_pos >= v_active, and 0 otherwise. Both blank and the sync outputs change on the same edge as the counters.
- R7: A write (wr_en=1) at wr_addr stores wr_data into the register at that address. The addresses are: 0 tuning word, 1 h_total, 2 h_active, 3 h_sync_start, 4 h_sync_end, 5 v_total, 6 v_active, 7 v_sync_start, 8 v_sync_end, 9 polarity (bit 0 horizontal, bit 1 vertical). Writes to any other address are ignored.
- R8: preset_load with index i < NUM_PRESETS (31) loads the following values, each computed from i. Horizontal: active 16+4i, sync 18+4i to 22+4i, total 26+4i. Vertical: active 8+2i, sync 9+2i to 11+2i, total 13+2i. Polarity: horizontal = i bit 0, vertical = i bit 1. Tuning word: ((i mod 4)+1)<<(ACC_W-3).
- R9: preset_load with an index >= NUM_PRESETS leaves every register unchanged.
- R10: A trim_up pulse adds 1 to the tuning word and a trim_down pulse subtracts 1. The word saturates at all-ones and at zero, and both pulses together leave it unchanged. A write takes precedence over a preset load in the same cycle, and a preset load takes precedence over a trim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that runs the accumulator |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | DATA_W | Register write value |
| preset_load | input | 1 | Load the mode selected by preset_sel |
| preset_sel | input | SEL_W | Preset index |
| trim_up | input | 1 | Raise the tuning word by one step |
| trim_down | input | 1 | Lower the tuning word by one step |
| pix_tick | output | 1 | One-cycle pixel tick from the accumulator carry |
| h_pos | output | CNT_W | Horizontal position |
| v_pos | output | CNT_W | Vertical position |
| hsync | output | 1 | Horizontal sync at its programmed polarity |
| vsync | output | 1 | Vertical sync at its programmed polarity |
| blank | output | 1 | High outside the visible area |

## Verification
A wrong accumulator or tuning word shows up as a pixel-tick count over a 2^ACC_W-clock window that differs from the tuning word, so every such fault is seen within one window. A counter, wrap or sync-window fault appears at h_pos, v_pos or the sync and blank pins on the first cycle where a reference model that steps on the observed ticks disagrees with them. That takes at most one line for horizontal faults and one frame for vertical faults. A register that a write, preset, ignored preset or trim left in the wrong state is exposed through these same tick counts and raster comparisons.

// File: rtl/nsg_pkg.sv
package nsg_pkg;

  typedef enum logic [3:0] {
    RA_STEP     = 4'd0,
    RA_H_TOTAL  = 4'd1,
    RA_H_ACTIVE = 4'd2,
    RA_H_SSTART = 4'd3,
    RA_H_SEND   = 4'd4,
    RA_V_TOTAL  = 4'd5,
    RA_V_ACTIVE = 4'd6,
    RA_V_SSTART = 4'd7,
    RA_V_SEND   = 4'd8,
    RA_POL      = 4'd9
  } reg_addr_e;

  // field order inside one axis: 0 total, 1 active, 2 sync start, 3 sync end
  localparam int NUM_FIELDS = 4;
  localparam int NUM_AXES   = 2;

  function automatic int preset_field(int idx, int ax, int fld);
    int base;
    base = (ax == 0) ? 16 + 4 * idx : 8 + 2 * idx;
    case (fld)
      0:       return base + ((ax == 0) ? 10 : 5);
      1:       return base;
      2:       return base + ((ax == 0) ? 2 : 1);
      default: return base + ((ax == 0) ? 6 : 3);
    endcase
  endfunction

endpackage

// File: rtl/nsg_nco.sv
module nsg_nco #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] step,
  output logic             tick
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum = {1'b0, acc} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      tick <= 1'b0;
    end else begin
      acc  <= sum[ACC_W-1:0];
      tick <= sum[ACC_W];
    end
  end
endmodule

// File: rtl/nsg_axis.sv
module nsg_axis #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] total,
  input  logic [CNT_W-1:0] active,
  input  logic [CNT_W-1:0] s_start,
  input  logic [CNT_W-1:0] s_end,
  output logic [CNT_W-1:0] count,
  output logic             wrap,
  output logic             in_active,
  output logic             in_sync
);
  assign wrap      = ({1'b0, count} + 1'b1) >= {1'b0, total};
  assign in_active = count < active;
  assign in_sync   = (count >= s_start) && (count < s_end);

  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (adv) count <= wrap ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/nsg_regs.sv
module nsg_regs #(
  parameter int ACC_W       = 32,
  parameter int CNT_W       = 12,
  parameter int DATA_W      = 32,
  parameter int NUM_PRESETS = 31,
  parameter int SEL_W       = 5
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [3:0]                  wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        preset_load,
  input  logic [SEL_W-1:0]            preset_sel,
  input  logic                        trim_up,
  input  logic                        trim_down,
  output logic [ACC_W-1:0]            step_q,
  output logic [1:0][3:0][CNT_W-1:0]  cfg_q,
  output logic [1:0]                  pol_q
);
  import nsg_pkg::*;

  logic [1:0][3:0][CNT_W-1:0] pre_cfg, rst_cfg;
  logic [ACC_W-1:0]           pre_step, rst_step;
  logic                       preset_ok;
  logic [3:0]                 widx;
  logic                       wcfg;

  for (genvar a = 0; a < NUM_AXES; a++) begin : g_ax
    for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_fld
      assign pre_cfg[a][f] = CNT_W'(preset_field(int'(preset_sel), a, f));
      assign rst_cfg[a][f] = CNT_W'(preset_field(0, a, f));
    end
  end

  assign pre_step  = ACC_W'(preset_sel[1:0] + 3'd1) << (ACC_W - 3);
  assign rst_step  = ACC_W'(1) << (ACC_W - 3);
  assign preset_ok = int'(preset_sel) < NUM_PRESETS;
  assign widx      = wr_addr - 4'd1;
  assign wcfg      = (wr_addr >= RA_H_TOTAL) && (wr_addr <= RA_V_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q <= rst_step;
      cfg_q  <= rst_cfg;
      pol_q  <= 2'b00;
    end else if (wr_en) begin
      if (wr_addr == RA_STEP) step_q <= wr_data[ACC_W-1:0];
      if (wr_addr == RA_POL)  pol_q  <= wr_data[1:0];
      for (int a = 0; a < NUM_AXES; a++)
        for (int f = 0; f < NUM_FIELDS; f++)
          if (wcfg && widx[2] == a[0] && widx[1:0] == f[1:0])
            cfg_q[a][f] <= wr_data[CNT_W-1:0];
    end else if (preset_load) begin
      if (preset_ok) begin
        step_q <= pre_step;
        cfg_q  <= pre_cfg;
        pol_q  <= {preset_sel[1], preset_sel[0]};
      end
    end else if (trim_up && !trim_down) begin
      if (step_q != '1) step_q <= step_q + 1'b1;
    end else if (trim_down && !trim_up) begin
      if (step_q != '0) step_q <= step_q - 1'b1;
    end
  end
endmodule

// File: rtl/nco_sync_gen.sv
module nco_sync_gen #(
  parameter int ACC_W       = 32,
  parameter int CNT_W       = 12,
  parameter int DATA_W      = 32,
  parameter int NUM_PRESETS = 31,
  localparam int SEL_W      = $clog2(NUM_PRESETS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              preset_load,
  input  logic [SEL_W-1:0]  preset_sel,
  input  logic              trim_up,
  input  logic              trim_down,
  output logic              pix_tick,
  output logic [CNT_W-1:0]  h_pos,
  output logic [CNT_W-1:0]  v_pos,
  output logic              hsync,
  output logic              vsync,
  output logic              blank
);
  logic [ACC_W-1:0]           step_q;
  logic [1:0][3:0][CNT_W-1:0] cfg_q;
  logic [1:0]                 pol_q;
  logic [1:0][CNT_W-1:0]      pos;
  logic [1:0]                 adv, wrap, act, syn;

  nsg_regs #(
    .ACC_W(ACC_W), .CNT_W(CNT_W), .DATA_W(DATA_W),
    .NUM_PRESETS(NUM_PRESETS), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .preset_load(preset_load), .preset_sel(preset_sel),
    .trim_up(trim_up), .trim_down(trim_down),
    .step_q(step_q), .cfg_q(cfg_q), .pol_q(pol_q)
  );

  nsg_nco #(.ACC_W(ACC_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .step(step_q), .tick(pix_tick)
  );

  assign adv[0] = pix_tick;
  assign adv[1] = pix_tick & wrap[0];

  for (genvar a = 0; a < 2; a++) begin : g_axis
    nsg_axis #(.CNT_W(CNT_W)) u_axis (
      .clk(clk), .rst_n(rst_n), .adv(adv[a]),
      .total(cfg_q[a][0]), .active(cfg_q[a][1]),
      .s_start(cfg_q[a][2]), .s_end(cfg_q[a][3]),
      .count(pos[a]), .wrap(wrap[a]), .in_active(act[a]), .in_sync(syn[a])
    );
  end

  assign h_pos = pos[0];
  assign v_pos = pos[1];
  assign hsync = ~(syn[0] ^ pol_q[0]);
  assign vsync = ~(syn[1] ^ pol_q[1]);
  assign blank = ~(act[0] & act[1]);
endmodule

// File: rtl/nsg_checker.sv
module nsg_checker #(
  parameter int ACC_W       = 32,
  parameter int CNT_W       = 12,
  parameter int NUM_PRESETS = 31,
  parameter int SEL_W       = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_en,
  input logic                       preset_load,
  input logic [SEL_W-1:0]           preset_sel,
  input logic                       trim_up,
  input logic                       trim_down,
  input logic                       pix_tick,
  input logic [CNT_W-1:0]           h_pos,
  input logic [CNT_W-1:0]           v_pos,
  input logic                       hsync,
  input logic [ACC_W-1:0]           step_q,
  input logic [1:0][3:0][CNT_W-1:0] cfg_q,
  input logic [1:0]                 pol_q
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= rst_n;

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$past(pix_tick) |-> ($stable(h_pos) && $stable(v_pos)));

  p_vstep_on_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    !$stable(v_pos) |-> ($past(pix_tick) &&
      (({1'b0, $past(h_pos)} + 1'b1) >= {1'b0, $past(cfg_q[0][0])})));

  p_zero_step_r2: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    ($past(step_q) == '0) |-> !pix_tick);

  p_bad_preset_r9: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(preset_load && (int'(preset_sel) >= NUM_PRESETS) && !wr_en && !trim_up && !trim_down)
      |-> ($stable(cfg_q) && $stable(step_q) && $stable(pol_q)));

  p_trim_sat_r10: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    $past(trim_up && !trim_down && !wr_en && !preset_load && (step_q == '1)) |-> (step_q == '1));

  p_hs_idle_r5: assert property (@(posedge clk) disable iff (!rst_n || !past_ok)
    (h_pos < cfg_q[0][2]) |-> (hsync == !pol_q[0]));
endmodule

bind nco_sync_gen nsg_checker #(
  .ACC_W(ACC_W), .CNT_W(CNT_W), .NUM_PRESETS(NUM_PRESETS), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .preset_load(preset_load),
  .preset_sel(preset_sel), .trim_up(trim_up), .trim_down(trim_down),
  .pix_tick(pix_tick), .h_pos(h_pos), .v_pos(v_pos), .hsync(hsync),
  .step_q(step_q), .cfg_q(cfg_q), .pol_q(pol_q)
);

// File: tb/sim_nco_sync_gen.sv
module sim_nco_sync_gen;
  localparam int AW = 8;
  localparam int CW = 12;
  localparam int WIN = 1 << AW;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, wr_en = 1'b0, preset_load = 1'b0, trim_up = 1'b0, trim_down = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0] preset_sel = '0;
  logic pix_tick, hsync, vsync, blank;
  logic [CW-1:0] h_pos, v_pos;

  nco_sync_gen #(.ACC_W(AW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .preset_load(preset_load), .preset_sel(preset_sel), .trim_up(trim_up),
    .trim_down(trim_down), .pix_tick(pix_tick), .h_pos(h_pos), .v_pos(v_pos),
    .hsync(hsync), .vsync(vsync), .blank(blank)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  int mht, mha, mhs0, mhs1, mvt, mva, mvs0, mvs1, mh, mv;
  bit mhp, mvp;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); wr_en = 1; wr_addr = 4'(a); wr_data = 32'(d);
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(bit up, bit dn, bit ld, int sel);
    @(negedge clk); trim_up = up; trim_down = dn; preset_load = ld; preset_sel = 5'(sel);
    @(negedge clk); trim_up = 0; trim_down = 0; preset_load = 0;
  endtask

  task automatic tick_count(string req, int exp);
    int c = 0;
    repeat (3) @(negedge clk);
    repeat (WIN) begin @(negedge clk); c += int'(pix_tick); end
    check(c == exp, req, "ticks per window", c, exp);
  endtask

  function automatic void model_preset(int i);
    mha = 16 + 4 * i; mhs0 = mha + 2; mhs1 = mha + 6; mht = mha + 10;
    mva = 8 + 2 * i;  mvs0 = mva + 1; mvs1 = mva + 3; mvt = mva + 5;
    mhp = i[0]; mvp = i[1];
  endfunction

  task automatic track(int n, string req);
    bit pt;
    bit e_hs, e_vs, e_bl;
    longint act, exp;
    @(negedge clk);
    mh = int'(h_pos); mv = int'(v_pos); pt = pix_tick;
    repeat (n) begin
      @(negedge clk);
      if (pt) begin
        if (mh + 1 >= mht) begin
          mh = 0;
          if (mv + 1 >= mvt) mv = 0; else mv++;
        end else mh++;
      end
      e_hs = (mh >= mhs0 && mh < mhs1) ? mhp : !mhp;
      e_vs = (mv >= mvs0 && mv < mvs1) ? mvp : !mvp;
      e_bl = (mh >= mha) || (mv >= mva);
      exp = {CW'(mh), CW'(mv), e_hs, e_vs, e_bl};
      act = {h_pos, v_pos, hsync, vsync, blank};
      check(act == exp, req, "{h,v,hs,vs,blank}", act, exp);
      pt = pix_tick;
    end
  endtask

  task automatic t_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(h_pos == 0 && v_pos == 0, "R1", "counters in reset", {h_pos, v_pos}, 0);
    check({pix_tick, hsync, vsync, blank} == 4'b0110, "R1", "tick/hs/vs/blank in reset",
          {pix_tick, hsync, vsync, blank}, 4'b0110);
    rst_n = 1;
    @(negedge clk);
    check(h_pos == 0 && v_pos == 0 && !pix_tick, "R1", "first cycle after reset",
          {pix_tick, h_pos, v_pos}, 0);
    tick_count("R1 R2 preset0 step", 32);
  endtask

  task automatic t_step();
    wr(0, 64);  tick_count("R2 R7 step 64", 64);
    wr(0, 0);   tick_count("R2 step 0", 0);
    wr(0, 200); tick_count("R2 step 200", 200);
    wr(12, 5);  tick_count("R7 unused address", 200);
  endtask

  task automatic t_custom();
    wr(1, 10); wr(2, 6); wr(3, 7); wr(4, 9);
    wr(5, 4);  wr(6, 3); wr(7, 3); wr(8, 4);
    wr(9, 1);
    mht = 10; mha = 6; mhs0 = 7; mhs1 = 9;
    mvt = 4;  mva = 3; mvs0 = 3; mvs1 = 4;
    mhp = 1;  mvp = 0;
    track(600, "R3 R4 R5 R6 R7 custom");
  endtask

  task automatic t_preset();
    pulse(0, 0, 1, 5);
    model_preset(5);
    track(5000, "R8 R3 R4 R5 R6 preset5");
    tick_count("R8 preset5 step", 64);
  endtask

  task automatic t_bad_preset();
    pulse(0, 0, 1, 31);
    track(400, "R9 ignored index");
    tick_count("R9 step kept", 64);
  endtask

  task automatic t_trim();
    wr(0, 63);       pulse(1, 0, 0, 0); tick_count("R10 trim up", 64);
    pulse(0, 1, 0, 0); pulse(0, 1, 0, 0); tick_count("R10 trim down x2", 62);
    wr(0, 255);      pulse(1, 0, 0, 0); tick_count("R10 saturate high", 255);
    wr(0, 0);        pulse(0, 1, 0, 0); tick_count("R10 saturate low", 0);
    wr(0, 40);       pulse(1, 1, 0, 0); tick_count("R10 both pulses", 40);
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 100; trim_up = 1; preset_load = 1; preset_sel = 2;
    @(negedge clk); wr_en = 0; trim_up = 0; preset_load = 0;
    tick_count("R10 write wins", 100);
    pulse(0, 1, 1, 0); tick_count("R10 preset wins over trim", 32);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_step();
    t_custom();
    t_preset();
    t_bad_preset();
    t_trim();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule